// File: doc/BRIEF.md
# Interval Latency Statistics Counter

This block times intervals that a monitored event marks with a begin strobe and an end strobe. It counts each interval in clock cycles and keeps five running statistics over every interval it accepts: the number of intervals, the sum of their lengths, the sum of the squared lengths, the shortest length and the longest length. Software uses the count and the two sums to work out the mean and the spread of the latency.

The counter follows shared commands for clear, start, stop and sample, as the plain event counters beside it do. A sample copies every statistic and both status flags into a snapshot. Software reads the snapshot one word at a time through a single data port. A rewind strobe returns the read pointer to the first word, and each read strobe moves it to the next one. A result is trustworthy only when neither status flag is set.

The counter width `CW` is a parameter and must be even. An interval length is held in `CW/2` bits, so its square always fits in one counter word.

Top module: `lat_stat_acc`

## Requirements
- R1: After reset or a clear, the count, the sum and the sum of squares are zero, the minimum is all ones, the maximum is zero, and both status flags are zero. A clear and a start in the same cycle both take effect.
- R2: An interval whose begin strobe is sampled at clock edge t and whose end strobe is sampled at edge t+L has latency L (L ≥ 1). Each such interval adds one to the count.
- R3: Each accepted interval adds L to the sum and L*L to the sum of squares.
- R4: Over the intervals accepted since the last clear, the minimum holds the smallest L and the maximum holds the largest L.
- R5: A begin strobe is ignored while the counter is stopped and while an interval is already open. A stop discards an open interval, and a later end strobe then adds nothing.
- R6: When an open interval reaches the largest value the `CW/2`-bit timer can hold and has not ended, the overflow flag sets. The timer then holds that value, and the interval is recorded with it.
- R7: If accepting an interval would wrap the count, the sum or the sum of squares, the full flag sets and that interval is discarded. No later interval changes any statistic until the next clear.
- R8: A sample copies all statistics and both flags into the snapshot. The data port and the status outputs show only the snapshot, which stays unchanged until the next sample.
- R9: The read order is item 0 count, item 1 sum, item 2 sum of squares, item 3 {maximum in the upper half, minimum in the lower half}. A rewind selects item 0. Each read strobe advances by one item, and after item 3 the pointer wraps to item 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_clear | input | 1 | Clear all statistics and flags |
| cmd_start | input | 1 | Enable measuring |
| cmd_stop | input | 1 | Disable measuring and drop the open interval |
| cmd_sample | input | 1 | Copy statistics and flags into the snapshot |
| ev_begin | input | 1 | Begin strobe of the monitored event |
| ev_end | input | 1 | End strobe of the monitored event |
| rd_rewind | input | 1 | Set the read pointer to item 0 |
| rd_next | input | 1 | Read strobe; advances the read pointer |
| rd_data | output | CW | Snapshot word selected by the read pointer |
| stat_ovf | output | 1 | Sampled overflow flag |
| stat_full | output | 1 | Sampled full flag |

## Verification
The bench builds the block with `CW = 8`, so the interval timer is 4 bits wide and saturates at 15. With this narrow width every representable latency from 1 to 14 can be swept one at a time. Timer saturation is reached by a 20-cycle interval. A rising run of intervals 1, 2, 3, … fills the 8-bit sum of squares at the ninth interval, so the full flag and the blocking of every later update are checked within a few hundred cycles, against a model that keeps the totals at a wider width.

// File: rtl/lat_stat_acc.sv
module lat_stat_acc #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_clear,
  input  logic          cmd_start,
  input  logic          cmd_stop,
  input  logic          cmd_sample,
  input  logic          ev_begin,
  input  logic          ev_end,
  input  logic          rd_rewind,
  input  logic          rd_next,
  output logic [CW-1:0] rd_data,
  output logic          stat_ovf,
  output logic          stat_full
);
  localparam int LW = CW / 2;
  localparam logic [LW-1:0] LMAX = '1;

  logic          run, busy, ovf, full;
  logic [LW-1:0] tmr, lmin, lmax;
  logic [CW-1:0] n, sum, sq;
  logic [CW-1:0] s_n, s_sum, s_sq, s_mm;
  logic [1:0]    idx;

  wire          fin    = run & busy & ev_end;
  wire [CW-1:0] tmr_w  = CW'(tmr);
  wire [CW-1:0] sqr    = tmr_w * tmr_w;
  wire [CW:0]   n_nx   = {1'b0, n} + 1'b1;
  wire [CW:0]   sum_nx = {1'b0, sum} + {1'b0, tmr_w};
  wire [CW:0]   sq_nx  = {1'b0, sq} + {1'b0, sqr};
  wire          wrap   = n_nx[CW] | sum_nx[CW] | sq_nx[CW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; busy <= 1'b0; ovf <= 1'b0; full <= 1'b0;
      tmr <= '0; lmin <= '1; lmax <= '0;
      n <= '0; sum <= '0; sq <= '0;
    end else begin
      if (cmd_clear) begin
        busy <= 1'b0; ovf <= 1'b0; full <= 1'b0;
        lmin <= '1; lmax <= '0;
        n <= '0; sum <= '0; sq <= '0;
      end else if (cmd_stop) begin
        busy <= 1'b0;
      end else if (fin) begin
        busy <= 1'b0;
        if (!full) begin
          if (wrap) full <= 1'b1;
          else begin
            n   <= n_nx[CW-1:0];
            sum <= sum_nx[CW-1:0];
            sq  <= sq_nx[CW-1:0];
            if (tmr < lmin) lmin <= tmr;
            if (tmr > lmax) lmax <= tmr;
          end
        end
      end else if (busy) begin
        if (tmr == LMAX) ovf <= 1'b1;
        else tmr <= tmr + 1'b1;
      end else if (run && ev_begin) begin
        busy <= 1'b1;
        tmr  <= LW'(1);
      end
      if (cmd_stop) run <= 1'b0;
      else if (cmd_start) run <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_n <= '0; s_sum <= '0; s_sq <= '0; s_mm <= '0;
      stat_ovf <= 1'b0; stat_full <= 1'b0; idx <= '0;
    end else begin
      if (cmd_sample) begin
        s_n <= n; s_sum <= sum; s_sq <= sq; s_mm <= {lmax, lmin};
        stat_ovf <= ovf; stat_full <= full;
      end
      if (rd_rewind) idx <= '0;
      else if (rd_next) idx <= idx + 1'b1;
    end
  end

  always_comb begin
    case (idx)
      2'd0:    rd_data = s_n;
      2'd1:    rd_data = s_sum;
      2'd2:    rd_data = s_sq;
      default: rd_data = s_mm;
    endcase
  end

  // R4
  min_le_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (n != '0) |-> (lmin <= lmax));
  // R2
  n_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_clear |=> (n >= $past(n)));
  // R7
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmd_clear) |=> full);
  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cmd_clear) |=> ($stable(n) && $stable(sum) && $stable(sq)));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_sample |=> ($stable(s_n) && $stable(s_sum) && $stable(s_sq) && $stable(s_mm)));
  // R1
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (n == '0 && sum == '0 && sq == '0 && !full && !ovf));
endmodule

// File: tb/lat_stat_acc_test.sv
`timescale 1ns/1ps
module lat_stat_acc_test;
  localparam int CW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_clear = 0, cmd_start = 0, cmd_stop = 0, cmd_sample = 0;
  logic ev_begin = 0, ev_end = 0, rd_rewind = 0, rd_next = 0;
  logic [CW-1:0] rd_data;
  logic stat_ovf, stat_full;
  int tests = 0, fails = 0;
  int en, es, eq, emin, emax, efull;

  lat_stat_acc #(.CW(CW)) uut (.*);

  always #2.5 clk = ~clk;

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(bit c, bit st, bit sp, bit sm, bit rw);
    cmd_clear = c; cmd_start = st; cmd_stop = sp; cmd_sample = sm; rd_rewind = rw;
    @(negedge clk);
    cmd_clear = 0; cmd_start = 0; cmd_stop = 0; cmd_sample = 0; rd_rewind = 0;
  endtask

  task automatic measure(int l);
    ev_begin = 1;
    @(negedge clk) ev_begin = 0;
    repeat (l - 1) @(negedge clk);
    ev_end = 1;
    @(negedge clk) ev_end = 0;
  endtask

  task automatic rd(string req, int exp);
    chk(req, rd_data, exp);
    rd_next = 1;
    @(negedge clk) rd_next = 0;
  endtask

  task automatic mreset();
    en = 0; es = 0; eq = 0; emin = 15; emax = 0; efull = 0;
  endtask

  task automatic madd(int l);
    if (efull != 0) return;
    if (en + 1 > 255 || es + l > 255 || eq + l * l > 255) efull = 1;
    else begin
      en++; es += l; eq += l * l;
      if (l < emin) emin = l;
      if (l > emax) emax = l;
    end
  endtask

  task automatic check_all(string req, int ovf);
    cmd(0, 0, 0, 1, 1);
    rd({req, " R9 n"}, en);
    rd({req, " R3 sum"}, es);
    rd({req, " R3 sq"}, eq);
    rd({req, " R4 minmax"}, emax * 16 + emin);
    chk({req, " R7 full"}, stat_full, efull);
    chk({req, " R6 ovf"}, stat_ovf, ovf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mreset();
    check_all("R1 reset", 0);

    // R2 sweep of single latencies
    for (int l = 1; l <= 14; l++) begin
      cmd(1, 1, 0, 0, 0);
      mreset();
      measure(l); madd(l);
      @(negedge clk);
      check_all("R2 single", 0);
    end

    // R3 R4 R7 rising run, full at ninth interval
    cmd(1, 1, 0, 0, 0);
    mreset();
    for (int l = 1; l <= 8; l++) begin measure(l); madd(l); end
    check_all("R3 run8", 0);
    for (int l = 9; l <= 11; l++) begin measure(l); madd(l); end
    check_all("R7 run11", 0);
    chk("R7 full model", efull, 1);

    // R4 unordered lengths
    cmd(1, 1, 0, 0, 0);
    mreset();
    measure(6); madd(6); measure(2); madd(2); measure(9); madd(9); measure(4); madd(4);
    check_all("R4 mix", 0);

    // R6 saturation
    cmd(1, 1, 0, 0, 0);
    mreset();
    measure(20); madd(15);
    check_all("R6 sat", 1);
    cmd(1, 0, 0, 0, 0);
    mreset();
    check_all("R1 clear", 0);

    // R5 stopped, in-flight stop, begin while busy
    cmd(0, 0, 1, 0, 0);
    measure(3);
    cmd(0, 1, 0, 0, 0);
    ev_begin = 1; @(negedge clk) ev_begin = 0;
    @(negedge clk);
    cmd(0, 0, 1, 0, 0);
    ev_end = 1; @(negedge clk) ev_end = 0;
    check_all("R5 ignored", 0);
    cmd(0, 1, 0, 0, 0);
    ev_begin = 1; @(negedge clk);
    @(negedge clk); ev_begin = 1;
    @(negedge clk) ev_begin = 0;
    @(negedge clk); @(negedge clk);
    ev_end = 1; @(negedge clk) ev_end = 0;
    madd(5);
    check_all("R5 rebegin", 0);

    // R8 snapshot holds
    measure(7);
    cmd(0, 0, 0, 0, 1);
    rd("R8 hold n", en);
    rd("R8 hold sum", es);

    // R9 wrap and rewind
    rd("R9 sq", eq);
    rd("R9 mm", emax * 16 + emin);
    rd("R9 wrap", en);
    cmd(0, 0, 0, 0, 1);
    rd("R9 rewind", en);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule